// File: doc/BRIEF.md
# Exclusive-OR Instruction Decode and Execute Unit

This unit takes one instruction word per cycle, either a 16-bit halfword or a 32-bit word, as chosen by a width input. It recognises three forms of the bitwise exclusive-OR operation:

- a narrow register form;
- a wide register form whose second operand passes through a barrel shifter;
- a wide form whose second operand is a modified immediate.

From the word it pulls out the register indices, the shift controls and the immediate. It presents the two source indices on combinational read-select outputs. The caller returns the operand values on the same cycle.

One clock edge after the word is presented, the unit registers its results:

- the XOR result and the destination index;
- a register write enable and a flag-update enable;
- the new N, Z and C values.

It also flags two cases. The first is the test-equivalence alias of the immediate form, where the destination is register 15 with flag setting on. The second is any register use with unpredictable behaviour. The register file, instruction fetch and conditional-block tracking are outside the unit. Whether the instruction sits inside a conditional block arrives on an input.

Top module: `xor_dx_unit`

## Requirements
- R1: With `is_wide`=0 and `instr[15:6]`=0100000001 the word is the narrow form. The destination and first source are `instr[2:0]`, the second source is `instr[5:3]` (both zero-extended to 4 bits), the second operand is not shifted, and the result is `rn_val ^ rm_val`.
- R2: The narrow form updates flags only when `in_it_block` is 0. Its C output equals `carry_in`.
- R3: With `is_wide`=1 and `instr[31:21]`=11101010100 the word is the wide register form. The fields are:
  - Rn = `instr[19:16]`, Rd = `instr[11:8]`, Rm = `instr[3:0]`;
  - shift type = `instr[5:4]`, with 0 LSL, 1 LSR, 2 ASR, 3 ROR;
  - shift amount = {`instr[14:12]`,`instr[7:6]`}.

  The result is `rn_val` XOR the shifted `rm_val`.
- R4: The shifter handles a nonzero amount n as follows. LSL gives carry = bit 32-n of the input. LSR and ASR give carry = bit n-1. ROR gives carry = bit 31 of the result. A zero amount means LSL #0 (carry = `carry_in`), LSR #32 or ASR #32 (carry = input bit 31), or for ROR a rotate right by one through `carry_in` (carry = input bit 0).
- R5: With `is_wide`=1 the word is the wide immediate form when all of these hold:
  - `instr[31:27]`=11110;
  - bit 25 = 0;
  - `instr[24:21]`=0100;
  - bit 15 = 0.

  The 12-bit code is {bit 26, `instr[14:12]`, `instr[7:0]`}. Its expansion works as follows:
  - If code[11:10]=00, the byte code[7:0] is placed according to code[9:8]: 0 gives 000000XY, 1 gives 00XY00XY, 2 gives XY00XY00, 3 gives XYXYXYXY. Carry is then `carry_in`.
  - Otherwise {1,code[6:0]} is rotated right by code[11:7], and carry is bit 31 of that value.
- R6: The wide forms update flags only when `instr[20]` is 1.
- R7: An immediate form with Rd=15 and `instr[20]`=1 raises `out_alias_test`. It clears `out_wr_en` and `out_flag_we`, and does not raise `out_unpred`.
- R8: `out_unpred` rises in the following cases:
  - the wide register form with Rd, Rn or Rm equal to 13 or 15;
  - the wide register form with `instr[15]`=1;
  - the wide immediate form, other than the alias, with Rd or Rn equal to 13 or 15.

  It never rises for the narrow form.
- R9: `out_n` is result bit 31 and `out_z` is 1 exactly when the result is zero. When `out_flag_we` is 0, `out_c` equals `carry_in`.
- R10: A word matching none of the three forms, or `in_valid`=0, gives `out_valid`=0, `out_wr_en`=0 and `out_flag_we`=0 on the next cycle.
- R11: All registered outputs appear one rising edge after the inputs. While `rst_n`=0, `out_valid`, `out_wr_en` and `out_flag_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| is_wide | input | 1 | 1: 32-bit word, 0: halfword in instr[15:0] |
| instr | input | 32 | Instruction word |
| in_it_block | input | 1 | Instruction lies in a conditional block |
| carry_in | input | 1 | Current C flag |
| rn_sel | output | 4 | First source read index (combinational) |
| rm_sel | output | 4 | Second source read index (combinational) |
| rn_val | input | 32 | First source value |
| rm_val | input | 32 | Second source value |
| out_valid | output | 1 | Registered: a matching instruction was accepted |
| out_rd | output | 4 | Destination index |
| out_wr_en | output | 1 | Register write enable |
| out_result | output | 32 | XOR result |
| out_flag_we | output | 1 | Flags are to be updated |
| out_n | output | 1 | Negative flag value |
| out_z | output | 1 | Zero flag value |
| out_c | output | 1 | Carry flag value |
| out_alias_test | output | 1 | Test-equivalence alias detected |
| out_unpred | output | 1 | Unpredictable register use |

## Verification
The read selects are combinational. The bench checks them after driving the word and before the rising edge. Every registered output is due one rising edge after the inputs are applied. The bench drives each word on a falling edge and compares all registered outputs on the next falling edge, half a period after the capturing edge. Each stimulus therefore occupies exactly one cycle, and results from neighbouring words never overlap in a comparison.

// File: rtl/xdx_pkg.sv
package xdx_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {K_NONE, K_NARROW, K_WREG, K_WIMM} form_e;
  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shkind_e;

  typedef struct packed {
    logic              match;
    form_e             form;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rm;
    shkind_e           shtype;
    logic [AMT_W-1:0]  shamt;
    logic [11:0]       imm12;
    logic              set_flags;
    logic              alias_test;
    logic              unpred;
  } dec_t;

  // Returns {carry, value}
  function automatic logic [DATA_W:0] xdx_shift(
    input logic [DATA_W-1:0] v, input shkind_e t,
    input logic [AMT_W-1:0] amt, input logic cin);
    logic [DATA_W:0] w;
    logic signed [DATA_W:0] s;
    logic [DATA_W-1:0] r;
    logic c;
    r = v;
    c = cin;
    case (t)
      SH_LSL: begin
        if (amt != '0) begin
          w = {1'b0, v} << amt;
          r = w[DATA_W-1:0];
          c = w[DATA_W];
        end
      end
      SH_LSR: begin
        if (amt == '0) begin
          r = '0; c = v[DATA_W-1];
        end else begin
          w = {v, 1'b0} >> amt;
          r = w[DATA_W:1]; c = w[0];
        end
      end
      SH_ASR: begin
        if (amt == '0) begin
          r = {DATA_W{v[DATA_W-1]}}; c = v[DATA_W-1];
        end else begin
          s = $signed({v, 1'b0}) >>> amt;
          r = s[DATA_W:1]; c = s[0];
        end
      end
      default: begin
        if (amt == '0) begin
          r = {cin, v[DATA_W-1:1]}; c = v[0];
        end else begin
          r = (v >> amt) | (v << (DATA_W - int'(amt)));
          c = r[DATA_W-1];
        end
      end
    endcase
    return {c, r};
  endfunction

  // Returns {carry, value}
  function automatic logic [DATA_W:0] xdx_expand(
    input logic [11:0] code, input logic cin);
    logic [7:0] b;
    logic [DATA_W-1:0] base, r;
    logic [4:0] rot;
    b = code[7:0];
    if (code[11:10] == 2'b00) begin
      case (code[9:8])
        2'd0:    r = {24'd0, b};
        2'd1:    r = {8'd0, b, 8'd0, b};
        2'd2:    r = {b, 8'd0, b, 8'd0};
        default: r = {b, b, b, b};
      endcase
      return {cin, r};
    end
    base = {24'd0, 1'b1, code[6:0]};
    rot  = code[11:7];
    r    = (base >> rot) | (base << (DATA_W - int'(rot)));
    return {r[DATA_W-1], r};
  endfunction
endpackage

// File: rtl/xdx_decode.sv
module xdx_decode
  import xdx_pkg::*;
(
  input  logic              is_wide,
  input  logic [INSN_W-1:0] instr,
  input  logic              in_it_block,
  output dec_t              dec
);
  localparam logic [9:0]  NARROW_OP = 10'b0100000001;
  localparam logic [10:0] WREG_OP   = 11'b11101010100;

  logic hit_narrow, hit_wreg, hit_wimm;
  logic [IDX_W-1:0] w_rd, w_rn, w_rm;

  function automatic logic bad_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(13)) || (i == IDX_W'(15));
  endfunction

  assign hit_narrow = !is_wide && (instr[15:6] == NARROW_OP);
  assign hit_wreg   = is_wide && (instr[31:21] == WREG_OP);
  assign hit_wimm   = is_wide && (instr[31:27] == 5'b11110) && !instr[25]
                      && (instr[24:21] == 4'b0100) && !instr[15];

  assign w_rn = instr[19:16];
  assign w_rd = instr[11:8];
  assign w_rm = instr[3:0];

  always_comb begin
    dec = '0;
    dec.form = K_NONE;
    dec.shtype = SH_LSL;
    dec.match = hit_narrow || hit_wreg || hit_wimm;
    if (hit_narrow) begin
      dec.form      = K_NARROW;
      dec.rd        = {1'b0, instr[2:0]};
      dec.rn        = {1'b0, instr[2:0]};
      dec.rm        = {1'b0, instr[5:3]};
      dec.set_flags = !in_it_block;
    end else if (hit_wreg) begin
      dec.form      = K_WREG;
      dec.rd        = w_rd;
      dec.rn        = w_rn;
      dec.rm        = w_rm;
      dec.shtype    = shkind_e'(instr[5:4]);
      dec.shamt     = {instr[14:12], instr[7:6]};
      dec.set_flags = instr[20];
      dec.unpred    = bad_idx(w_rd) || bad_idx(w_rn) || bad_idx(w_rm) || instr[15];
    end else if (hit_wimm) begin
      dec.form       = K_WIMM;
      dec.rd         = w_rd;
      dec.rn         = w_rn;
      dec.rm         = w_rm;
      dec.imm12      = {instr[26], instr[14:12], instr[7:0]};
      dec.set_flags  = instr[20];
      dec.alias_test = instr[20] && (w_rd == IDX_W'(15));
      dec.unpred     = !dec.alias_test && (bad_idx(w_rd) || bad_idx(w_rn));
    end
  end
endmodule

// File: rtl/xdx_operand.sv
module xdx_operand
  import xdx_pkg::*;
(
  input  form_e             form,
  input  shkind_e           shtype,
  input  logic [AMT_W-1:0]  shamt,
  input  logic [11:0]       imm12,
  input  logic [DATA_W-1:0] rm_val,
  input  logic              carry_in,
  output logic [DATA_W-1:0] op2,
  output logic              op2_carry
);
  logic [DATA_W:0] sh_out, ex_out;

  assign sh_out = xdx_shift(rm_val, shtype, shamt, carry_in);
  assign ex_out = xdx_expand(imm12, carry_in);

  always_comb begin
    if (form == K_WIMM) begin
      op2       = ex_out[DATA_W-1:0];
      op2_carry = ex_out[DATA_W];
    end else begin
      op2       = sh_out[DATA_W-1:0];
      op2_carry = sh_out[DATA_W];
    end
  end
endmodule

// File: rtl/xor_dx_unit.sv
module xor_dx_unit
  import xdx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              is_wide,
  input  logic [INSN_W-1:0] instr,
  input  logic              in_it_block,
  input  logic              carry_in,
  output logic [IDX_W-1:0]  rn_sel,
  output logic [IDX_W-1:0]  rm_sel,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_rd,
  output logic              out_wr_en,
  output logic [DATA_W-1:0] out_result,
  output logic              out_flag_we,
  output logic              out_n,
  output logic              out_z,
  output logic              out_c,
  output logic              out_alias_test,
  output logic              out_unpred
);
  dec_t              dec;
  logic [DATA_W-1:0] op2, xres;
  logic              op2_carry;
  logic              accept, dec_match, will_write, will_flag;

  xdx_decode u_dec (
    .is_wide(is_wide), .instr(instr), .in_it_block(in_it_block), .dec(dec)
  );

  xdx_operand u_opnd (
    .form(dec.form), .shtype(dec.shtype), .shamt(dec.shamt), .imm12(dec.imm12),
    .rm_val(rm_val), .carry_in(carry_in), .op2(op2), .op2_carry(op2_carry)
  );

  assign rn_sel     = dec.rn;
  assign rm_sel     = dec.rm;
  assign dec_match  = dec.match;
  assign accept     = in_valid && dec_match;
  assign will_write = accept && !dec.alias_test;
  assign will_flag  = accept && !dec.alias_test && dec.set_flags;
  assign xres       = rn_val ^ op2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_rd         <= '0;
      out_wr_en      <= 1'b0;
      out_result     <= '0;
      out_flag_we    <= 1'b0;
      out_n          <= 1'b0;
      out_z          <= 1'b0;
      out_c          <= 1'b0;
      out_alias_test <= 1'b0;
      out_unpred     <= 1'b0;
    end else begin
      out_valid      <= accept;
      out_rd         <= dec.rd;
      out_wr_en      <= will_write;
      out_result     <= xres;
      out_flag_we    <= will_flag;
      out_n          <= xres[DATA_W-1];
      out_z          <= (xres == '0);
      out_c          <= will_flag ? op2_carry : carry_in;
      out_alias_test <= accept && dec.alias_test;
      out_unpred     <= accept && dec.unpred;
    end
  end

  // R10
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !dec_match) |=> (!out_valid && !out_wr_en && !out_flag_we));

  // R7
  alias_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_alias_test |-> (!out_wr_en && !out_flag_we && !out_unpred));

  // R8
  narrow_no_unpred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_wide) |=> !out_unpred);

  // R2
  narrow_it_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_wide && in_it_block) |=> !out_flag_we);

  // R11
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_flag_we |-> (out_c == $past(carry_in)));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z == (out_result == '0)));
endmodule

// File: tb/sim_xor_dx_unit.sv
module sim_xor_dx_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, is_wide = 1'b0, in_it_block = 1'b0, carry_in = 1'b0;
  logic [31:0] instr = '0, rn_val = '0, rm_val = '0;
  logic [3:0]  rn_sel, rm_sel, out_rd;
  logic        out_valid, out_wr_en, out_flag_we, out_n, out_z, out_c;
  logic        out_alias_test, out_unpred;
  logic [31:0] out_result;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_dx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_wide(is_wide), .instr(instr),
    .in_it_block(in_it_block), .carry_in(carry_in), .rn_sel(rn_sel), .rm_sel(rm_sel),
    .rn_val(rn_val), .rm_val(rm_val), .out_valid(out_valid), .out_rd(out_rd),
    .out_wr_en(out_wr_en), .out_result(out_result), .out_flag_we(out_flag_we),
    .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_alias_test(out_alias_test),
    .out_unpred(out_unpred)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference shifter built on 64-bit arithmetic; returns {carry,value}
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [1:0] t,
                                            input int a, input logic c);
    logic [63:0] w;
    logic signed [63:0] sw;
    int n;
    case (t)
      2'd0: begin
        if (a == 0) return {c, v};
        w = {32'd0, v} << a;
        return {w[32], w[31:0]};
      end
      2'd1, 2'd2: begin
        n = (a == 0) ? 32 : a;
        if (t == 2'd1) w = {v, 32'd0} >> n;
        else begin sw = $signed({v, 32'd0}) >>> n; w = sw; end
        return {w[31], w[63:32]};
      end
      default: begin
        if (a == 0) return {v[0], c, v[31:1]};
        w = {v, v} >> a;
        return {w[31], w[31:0]};
      end
    endcase
  endfunction

  function automatic logic [32:0] ref_expand(input logic [11:0] k, input logic c);
    logic [31:0] b, base;
    logic [63:0] w;
    b = {24'd0, k[7:0]};
    if (k[11:10] == 2'b00) begin
      case (k[9:8])
        2'd0: return {c, b};
        2'd1: return {c, b * 32'h0001_0001};
        2'd2: return {c, b * 32'h0100_0100};
        default: return {c, b * 32'h0101_0101};
      endcase
    end
    base = 32'h80 | {25'd0, k[6:0]};
    w = {base, base} >> k[11:7];
    return {w[31], w[31:0]};
  endfunction

  // drive on falling edge, check selects before rising edge, outputs next falling edge
  task automatic apply(input string tag, input logic [31:0] iw, input logic wide,
      input logic it, input logic cin, input logic [31:0] a, input logic [31:0] b,
      input logic vld, input logic e_valid, input logic [3:0] e_rd, input logic [3:0] e_rn,
      input logic [3:0] e_rm, input logic chk_rm, input logic e_we, input logic e_fwe,
      input logic [31:0] e_res, input logic e_c, input logic e_alias, input logic e_unp);
    instr = iw; is_wide = wide; in_it_block = it; carry_in = cin;
    rn_val = a; rm_val = b; in_valid = vld;
    #1;
    if (e_valid) begin
      cmp(tag, "rn_sel", {28'd0, rn_sel}, {28'd0, e_rn});
      if (chk_rm) cmp(tag, "rm_sel", {28'd0, rm_sel}, {28'd0, e_rm});
    end
    @(negedge clk);
    cmp(tag, "valid", {31'd0, out_valid}, {31'd0, e_valid});
    cmp(tag, "wr_en", {31'd0, out_wr_en}, {31'd0, e_we});
    cmp(tag, "flag_we", {31'd0, out_flag_we}, {31'd0, e_fwe});
    if (e_valid) begin
      cmp(tag, "alias", {31'd0, out_alias_test}, {31'd0, e_alias});
      cmp(tag, "unpred", {31'd0, out_unpred}, {31'd0, e_unp});
      if (!e_alias) begin
        cmp(tag, "rd", {28'd0, out_rd}, {28'd0, e_rd});
        cmp(tag, "result", out_result, e_res);
        cmp(tag, "n", {31'd0, out_n}, {31'd0, e_res[31]});
        cmp(tag, "z", {31'd0, out_z}, {31'd0, e_res == 32'd0});
      end
      cmp(tag, "c", {31'd0, out_c}, {31'd0, e_fwe ? e_c : cin});
    end
  endtask

  function automatic logic bad(input logic [3:0] i);
    return i == 4'd13 || i == 4'd15;
  endfunction

  task automatic narrow_op(input string tag, input logic [2:0] rdn, input logic [2:0] rm,
                           input logic it, input logic cin, input logic [31:0] a,
                           input logic [31:0] b);
    apply(tag, {16'h0, 16'h4040 | {10'd0, rm, rdn}}, 1'b0, it, cin, a, b, 1'b1, 1'b1,
          {1'b0, rdn}, {1'b0, rdn}, {1'b0, rm}, 1'b1, 1'b1, !it, a ^ b, cin, 1'b0, 1'b0);
  endtask

  task automatic wreg_op(input string tag, input logic s, input logic [3:0] rd,
      input logic [3:0] rn, input logic [3:0] rm, input logic [1:0] t, input logic [4:0] amt,
      input logic b15, input logic cin, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] iw;
    logic [32:0] sh;
    iw = 32'hEA80_0000 | {11'd0, s, rn, b15, amt[4:2], rd, amt[1:0], t, rm};
    sh = ref_shift(b, t, int'(amt), cin);
    apply(tag, iw, 1'b1, 1'b0, cin, a, b, 1'b1, 1'b1, rd, rn, rm, 1'b1, 1'b1, s,
          a ^ sh[31:0], sh[32], 1'b0, bad(rd) || bad(rn) || bad(rm) || b15);
  endtask

  task automatic wimm_op(input string tag, input logic s, input logic [3:0] rd,
      input logic [3:0] rn, input logic [11:0] k, input logic cin, input logic [31:0] a,
      input logic [31:0] b);
    logic [31:0] iw;
    logic [32:0] ex;
    logic al;
    iw = 32'hF080_0000 | {5'd0, k[11], 5'd0, s, rn, 1'b0, k[10:8], rd, k[7:0]};
    ex = ref_expand(k, cin);
    al = s && rd == 4'd15;
    apply(tag, iw, 1'b1, 1'b1, cin, a, b, 1'b1, 1'b1, rd, rn, 4'd0, 1'b0, !al, s && !al,
          a ^ ex[31:0], ex[32], al, !al && (bad(rd) || bad(rn)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    // R11 reset state
    cmp("R11", "valid in reset", {31'd0, out_valid}, 32'd0);
    cmp("R11", "wr_en in reset", {31'd0, out_wr_en}, 32'd0);
    cmp("R11", "flag_we in reset", {31'd0, out_flag_we}, 32'd0);
    rst_n = 1'b1;

    // R1 R2: every narrow index pair, inside and outside a conditional block
    for (int i = 0; i < 64; i++)
      for (int it = 0; it < 2; it++) begin
        a = $urandom; b = $urandom;
        if (i == 9) b = a;
        narrow_op(it ? "R2" : "R1", i[2:0], i[5:3], it[0], i[0] ^ it[0], a, b);
      end

    // R3 R4 R6 R9: every shift type and amount
    for (int t = 0; t < 4; t++)
      for (int m = 0; m < 32; m++)
        for (int k = 0; k < 3; k++) begin
          a = $urandom;
          b = (k == 0) ? 32'h8000_0001 : (k == 1 ? 32'h7FFF_FFFE : $urandom);
          wreg_op("R4", m[0], 4'd2, 4'd5, 4'd9, t[1:0], m[4:0], 1'b0, k[0], a, b);
        end
    wreg_op("R9", 1'b1, 4'd1, 4'd3, 4'd4, 2'd0, 5'd0, 1'b0, 1'b1, 32'h1234_5678,
            32'h1234_5678);
    wreg_op("R6", 1'b0, 4'd1, 4'd3, 4'd4, 2'd1, 5'd0, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF);

    // R8: register indices sweep for the wide register form, and bit 15
    for (int r = 0; r < 16; r++) begin
      wreg_op("R8", 1'b1, r[3:0], 4'd0, 4'd1, 2'd3, 5'd7, 1'b0, 1'b0, $urandom, $urandom);
      wreg_op("R8", 1'b1, 4'd0, r[3:0], 4'd1, 2'd2, 5'd3, 1'b0, 1'b1, $urandom, $urandom);
      wreg_op("R8", 1'b0, 4'd0, 4'd1, r[3:0], 2'd1, 5'd9, 1'b0, 1'b0, $urandom, $urandom);
    end
    wreg_op("R8", 1'b1, 4'd0, 4'd1, 4'd2, 2'd0, 5'd1, 1'b1, 1'b0, $urandom, $urandom);

    // R5: all 4096 immediate codes, both carry-in values, flag set alternating
    for (int k = 0; k < 4096; k++)
      wimm_op("R5", k[0], 4'd4, 4'd6, k[11:0], k[1], $urandom, 32'h0);

    // R7 R8: alias and index sweep in the immediate form
    for (int r = 0; r < 16; r++)
      for (int s = 0; s < 2; s++) begin
        wimm_op((r == 15 && s == 1) ? "R7" : "R8", s[0], r[3:0], 4'd2, 12'h4AB, 1'b0,
                $urandom, 32'h0);
        wimm_op("R8", s[0], 4'd3, r[3:0], 12'h1FF, 1'b1, $urandom, 32'h0);
      end

    // R10: non-matching words and idle cycles
    apply("R10", 32'h0000_4080, 1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 1'b1, 1'b0, 4'd0, 4'd0,
          4'd0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    apply("R10", 32'hEA80_0000, 1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 1'b1, 1'b0, 4'd0, 4'd0,
          4'd0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    apply("R10", 32'hEAA0_0000, 1'b1, 1'b0, 1'b0, 32'h5, 32'h6, 1'b1, 1'b0, 4'd0, 4'd0,
          4'd0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    apply("R10", 32'hF080_8000, 1'b1, 1'b0, 1'b0, 32'h5, 32'h6, 1'b1, 1'b0, 4'd0, 4'd0,
          4'd0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    apply("R10", 32'hF280_0000, 1'b1, 1'b0, 1'b0, 32'h5, 32'h6, 1'b1, 1'b0, 4'd0, 4'd0,
          4'd0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    apply("R10", 32'h0000_4041, 1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 1'b0, 1'b0, 4'd0, 4'd0,
          4'd0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule